// File: doc/BRIEF.md
# Fast A20 and Reset Control Port

This block is a one-byte system control register placed on a legacy byte-wide I/O bus. It responds at a single I/O address. Any write to that address is kept in full, and any read from it returns the kept byte. Two bits of the byte have side effects. Bit 1 drives the A20 gate line as a level. Bit 0, when it is written as one, sends a system reset request as a pulse one clock long.

There are two ways to reset the block. The asynchronous power-on reset clears the whole byte. The synchronous device-level soft reset clears only bit 0, the self-triggering reset bit. The other bits survive the soft reset, so the A20 setting is not lost when the rest of the platform is reset.

The surrounding fabric places accesses on the bus as one-cycle strobes. It reads the byte back in the same cycle as the read strobe.

Top module: `a20_sysctl_port`

## Requirements
- R1: While the asynchronous power-on reset is active, and after it is released, the stored byte is 0x00, `a20Gate` is 0 and `resetReq` is 0.
- R2: A write strobe with `ioAddr` equal to the port address (default 0x92) stores all 8 bits of `ioWdata`. A read strobe at that address returns the stored byte unchanged on `ioRdata` in the same cycle. A read does not modify the byte.
- R3: `a20Gate` equals bit 1 of the stored byte. It takes the written value at the clock edge that ends the write strobe cycle.
- R4: A write whose bit 0 is 1 drives `resetReq` high for exactly the one cycle that follows the write edge. A write whose bit 0 is 0 produces no pulse.
- R5: A stored bit 0 that stays at 1 does not raise `resetReq` again. Only a new qualifying write does.
- R6: A cycle with `softRst` high clears bit 0 of the stored byte at the next edge. Bits 7..1 and `a20Gate` keep their values, and no reset request is produced.
- R7: When `softRst` and a port write occur in the same cycle, the soft reset wins. The written byte is discarded and no pulse is produced.
- R8: Writes to any other address leave the byte unchanged. `ioRdata` is 0x00 whenever the read strobe is low or the address does not match.
- R9: Writes with bit 0 set in consecutive cycles produce a request pulse in each of the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low; clears the whole byte |
| softRst | input | 1 | Synchronous device reset; clears bit 0 only |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Byte write strobe, one cycle per access |
| ioRd | input | 1 | Byte read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data; zero unless a read hits the port |
| a20Gate | output | 1 | A20 gate level, bit 1 of the stored byte |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is a soft reset that arrives in the same cycle as a port write whose data differs from the stored byte in both A20 and reset bits. Only then can the bench see that the write was discarded, and not merged or partly applied. The bench first loads a byte with bit 1 clear. It then raises the soft reset together with a write of 0x03, and reads back to confirm that neither the A20 level nor a request moved. Back-to-back requesting writes and a long pseudo-random walk over the matching and a neighbouring address exercise the pulse spacing against a per-cycle reference model.

// File: rtl/a20_sysctl_pkg.sv
package a20_sysctl_pkg;

  typedef struct packed {
    logic load;    // capture the write byte
    logic clrLow;  // soft reset: clear the self-triggering bit
    logic fire;    // raise a reset request next cycle
    logic rdSel;   // drive the stored byte onto the read bus
  } ctlStrobes_t;

endpackage

// File: rtl/a20_sysctl_ctrl.sv
module a20_sysctl_ctrl
  import a20_sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              wdataRstBit,
  output ctlStrobes_t       st
);

  logic hit;

  assign hit = (ioAddr == PORT_ADDR);

  always_comb begin
    st        = '0;
    st.clrLow = softRst;
    st.load   = hit && ioWr && !softRst;
    st.fire   = hit && ioWr && !softRst && wdataRstBit;
    st.rdSel  = hit && ioRd;
  end

  // R7: a soft reset never coincides with a capture or a request
  p_soft_blocks_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (!st.load && !st.fire));

  // R8: strobes only for the decoded address
  p_decode_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr != PORT_ADDR) |-> (!st.load && !st.rdSel));

endmodule

// File: rtl/a20_sysctl_dp.sv
module a20_sysctl_dp
  import a20_sysctl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int A20_BIT = 1,
  parameter int RST_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       st,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              a20Gate,
  output logic              resetReq
);

  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << RST_BIT);

  logic [DATA_W-1:0] stored;
  logic              pulse;
  logic              pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stored    <= '0;
      pulse     <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      pulse     <= st.fire;
      if (st.clrLow)
        stored[RST_BIT] <= 1'b0;
      else if (st.load)
        stored <= wdata;
    end
  end

  assign a20Gate  = stored[A20_BIT];
  assign resetReq = pulse;
  assign rdata    = st.rdSel ? stored : '0;

  // R3: the A20 level takes the bit written in the previous cycle
  p_a20_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(st.load)) |-> (a20Gate == $past(wdata[A20_BIT])));

  // R4: a request pulse only after a capture with the reset bit set
  p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && resetReq) |-> ($past(st.load) && $past(wdata[RST_BIT])));

  // R6: a soft reset keeps the upper bits and clears the low bit
  p_soft_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(st.clrLow)) |->
      (((stored & KEEP_MASK) == ($past(stored) & KEEP_MASK)) && !stored[RST_BIT] && !resetReq));

  // R8: with no capture and no soft reset the byte holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(st.load) && !$past(st.clrLow)) |-> $stable(stored));

endmodule

// File: rtl/a20_sysctl_port.sv
module a20_sysctl_port
  import a20_sysctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
  parameter int A20_BIT = 1,
  parameter int RST_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              a20Gate,
  output logic              resetReq
);

  ctlStrobes_t st;

  a20_sysctl_ctrl #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .ioAddr     (ioAddr),
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .wdataRstBit(ioWdata[RST_BIT]),
    .st         (st)
  );

  a20_sysctl_dp #(
    .DATA_W (DATA_W),
    .A20_BIT(A20_BIT),
    .RST_BIT(RST_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wdata   (ioWdata),
    .rdata   (ioRdata),
    .a20Gate (a20Gate),
    .resetReq(resetReq)
  );

endmodule

// File: tb/a20_sysctl_port_tb.sv
module a20_sysctl_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PORT = 16'h0092;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = 8'h0;
  logic [7:0]  ioRdata;
  logic        a20Gate;
  logic        resetReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference
  logic [7:0] mdlByte;
  logic       mdlPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  a20_sysctl_port u_dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .a20Gate(a20Gate), .resetReq(resetReq)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdlByte  <= 8'h00;
      mdlPulse <= 1'b0;
    end else if (softRst) begin
      mdlByte  <= {mdlByte[7:1], 1'b0};
      mdlPulse <= 1'b0;
    end else if (ioWr && ioAddr == PORT) begin
      mdlByte  <= ioWdata;
      mdlPulse <= ioWdata[0];
    end else begin
      mdlPulse <= 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk("R3 a20 vs model", a20Gate, mdlByte[1]);
    chk("R4 pulse vs model", resetReq, mdlPulse);
    chk("R2/R8 rdata vs model", ioRdata, (ioRd && ioAddr == PORT) ? mdlByte : 8'h00);
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    step();
    ioWr = 1'b0;
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [7:0] exp, input string tag);
    ioAddr = a; ioRd = 1'b1;
    #2;
    chk(tag, ioRdata, exp);
    step();
    ioRd = 1'b0;
  endtask

  logic [7:0] lfsr = 8'h5B;

  initial begin
    #3;
    chk("R1 a20 in reset", a20Gate, 0);
    chk("R1 req in reset", resetReq, 0);
    step();
    rstN = 1'b1;
    step();
    rdChk(PORT, 8'h00, "R1 byte after reset");

    wr(PORT, 8'h02);
    chk("R3 a20 set after write edge", a20Gate, 1);
    chk("R4 no pulse for bit0=0", resetReq, 0);
    rdChk(PORT, 8'h02, "R2 readback 02");
    rdChk(PORT, 8'h02, "R2 read has no side effect");

    wr(PORT, 8'hA5);
    chk("R4 pulse after bit0 write", resetReq, 1);
    chk("R3 a20 cleared", a20Gate, 0);
    step();
    chk("R4 pulse one cycle", resetReq, 0);
    step(); step();
    chk("R5 no retrigger", resetReq, 0);
    rdChk(PORT, 8'hA5, "R2 full byte kept");

    softRst = 1'b1; step(); softRst = 1'b0;
    chk("R6 no pulse on soft reset", resetReq, 0);
    rdChk(PORT, 8'hA4, "R6 only bit0 cleared");

    wr(16'h0093, 8'hFF);
    rdChk(PORT, 8'hA4, "R8 other address ignored");
    rdChk(16'h0093, 8'h00, "R8 other address reads zero");
    ioAddr = PORT; #1;
    chk("R8 zero without read strobe", ioRdata, 0);

    softRst = 1'b1; wr(PORT, 8'h03); softRst = 1'b0;
    chk("R7 no pulse when soft reset wins", resetReq, 0);
    chk("R7 a20 unchanged", a20Gate, 0);
    rdChk(PORT, 8'hA4, "R7 write discarded");

    wr(PORT, 8'h01);
    chk("R9 first pulse", resetReq, 1);
    wr(PORT, 8'h03);
    chk("R9 second pulse", resetReq, 1);
    chk("R3 a20 from second write", a20Gate, 1);
    step();
    chk("R9 pulses end", resetReq, 0);

    wr(PORT, 8'hFF);
    softRst = 1'b1; step(); softRst = 1'b0;
    chk("R6 a20 kept through soft reset", a20Gate, 1);
    rdChk(PORT, 8'hFE, "R6 FF becomes FE");

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ioAddr  = lfsr[6] ? PORT : 16'h0093;
      ioWdata = {lfsr[3:0], lfsr[7:4]};
      ioWr    = lfsr[0];
      ioRd    = lfsr[1];
      softRst = (lfsr[7:5] == 3'b101);
      step();
    end
    ioWr = 1'b0; ioRd = 1'b0; softRst = 1'b0;

    wr(PORT, 8'h7E);
    #2 rstN = 1'b0; #1;
    chk("R1 async reset clears a20", a20Gate, 0);
    step();
    rstN = 1'b1;
    step();
    rdChk(PORT, 8'h00, "R1 async reset clears byte");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule